// File: doc/BRIEF.md
# Register-Programmed Backlight PWM Generator

This block drives one pulse-width-modulated line and one backlight-enable line, both set through a small byte-wide register interface. The interface has a write port with an address, data and write strobe, and a combinational read port with an address and data. Three byte registers are decoded: a divider byte, a duty byte and a backlight-enable byte. The divider byte holds a 7-bit ratio code and the PWM enable flag. A prescaler divides the incoming clock by the code plus one. Its tick advances an 8-bit period counter, so one period lasts 256 divided ticks. The line is high while the counter is below a shadowed copy of the duty byte.

Software first clears the enable flag, then loads a new ratio code, then sets the flag again. While the flag is clear the line stays low and the prescaler and counter are held at their start values. So each new enable begins a clean period. A duty byte written while running is taken into the shadow copy only when the counter wraps, so no period is cut short. The backlight-enable line does not depend on the PWM enable flag.

Top module: `bl_pwm_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00, `pwm_out` is low and `bl_en` is low.
- R2: A write with `wr_en` high stores `wr_data` at address 0x4B (divider), 0x4E (duty) or 0x51 (backlight). Reading such an address returns the stored byte unchanged. Any other address reads 0x00, and a write to it changes no register.
- R3: Bit 7 of the divider byte enables the PWM. While it is 0, `pwm_out` is low and the prescaler and period counter are held at zero.
- R4: With ratio code N in bits 6:0 of the divider byte, the period counter advances once every N+1 clocks, so one period lasts 256*(N+1) clocks.
- R5: In each period `pwm_out` is high for the first D*(N+1) clocks, where D is the applied duty byte. D = 0 gives a constant low, and D = 255 still gives a low final tick.
- R6: A duty byte written while the PWM is enabled takes effect from the next counter wrap. A duty byte written while the PWM is disabled applies from the first period after enable.
- R7: `bl_en` equals bit 0 of the byte at 0x51, changes one clock after the write, and is independent of divider bit 7.
- R8: Writing the divider byte with bit 7 clear and then again with a new code and bit 7 set restarts the period at counter zero with the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Read data, combinational from the stored bytes |
| pwm_out | output | 1 | PWM output line |
| bl_en | output | 1 | Backlight-enable line |

## Verification
A prescaler count that misses the ratio code stretches or shrinks every counter step. This shows as a wrong high-time total within the first period after enable. A shadow duty register that reloads at the wrong moment changes the high count of the period in which the duty byte was written. It is seen at most 256*(N+1) clocks later. A counter or prescaler that is not held while disabled gives a wrong first sample after re-enable, one clock after the enabling write. Register decode faults show at the read port in the clock after the write.

// File: rtl/bl_pwm_pkg.sv
// Package: shared constants for the backlight PWM generator.
// Assumes byte-wide registers and 8-bit addresses.
package bl_pwm_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 3;

    // Register slots; the index also selects the stored byte.
    localparam int SLOT_DIV  = 0;
    localparam int SLOT_DUTY = 1;
    localparam int SLOT_BLEN = 2;

    localparam logic [ADDR_W-1:0] ADDR_DIV  = 8'h4B;
    localparam logic [ADDR_W-1:0] ADDR_DUTY = 8'h4E;
    localparam logic [ADDR_W-1:0] ADDR_BLEN = 8'h51;

    function automatic logic [ADDR_W-1:0] slot_addr(input int slot);
        case (slot)
            SLOT_DIV:  return ADDR_DIV;
            SLOT_DUTY: return ADDR_DUTY;
            default:   return ADDR_BLEN;
        endcase
    endfunction
endpackage

// File: rtl/bl_pwm_regs.sv
// Module: bl_pwm_regs
// Holds the divider, duty and backlight bytes and drives the read mux.
// Assumes one write per clock; reads are combinational; unknown addresses read zero.
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = NUM_REGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] div_q,
    output logic [DW-1:0] duty_q,
    output logic [DW-1:0] blen_q
);
    logic [DW-1:0] store [NR];
    logic [NR-1:0] rd_hit;

    for (genvar g = 0; g < NR; g++) begin : g_reg
        localparam logic [AW-1:0] MY_ADDR = AW'(slot_addr(g));

        // Store the byte when the write targets this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[g] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
                store[g] <= wr_data;
        end

        assign rd_hit[g] = (rd_addr == MY_ADDR);
    end

    // OR together the bytes of the slot hit by the read address.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NR; i++)
            if (rd_hit[i]) rd_data = rd_data | store[i];
    end

    assign div_q  = store[SLOT_DIV];
    assign duty_q = store[SLOT_DUTY];
    assign blen_q = store[SLOT_BLEN];
endmodule

// File: rtl/bl_pwm_prescale.sv
// Module: bl_pwm_prescale
// Emits a one-clock tick every code+1 clocks while enabled.
// Assumes the count is held at zero while disabled; a code lowered mid-count ends the count at once.
module bl_pwm_prescale #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [CODE_W-1:0] cnt;

    assign tick = en && (cnt >= code);

    // Count base clocks between ticks; clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bl_pwm_core.sv
// Module: bl_pwm_core
// Period counter, shadow duty and compare producing the PWM line.
// Assumes the shadow duty loads freely while disabled and only at the counter wrap while enabled.
module bl_pwm_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] duty,
    output logic             pwm,
    output logic [CNT_W-1:0] pcnt,
    output logic [CNT_W-1:0] shadow
);
    localparam logic [CNT_W-1:0] LAST = '1;

    logic wrap;
    assign wrap = tick && (pcnt == LAST);

    // Advance the period counter on each tick; hold at zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            pcnt <= '0;
        else if (tick)
            pcnt <= pcnt + 1'b1;
    end

    // Take a new duty only while disabled or at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= '0;
        else if (!en || wrap)
            shadow <= duty;
    end

    assign pwm = en && (pcnt < shadow);
endmodule

// File: rtl/bl_pwm_top.sv
// Module: bl_pwm_top
// Register-programmed single-channel PWM with a separate backlight-enable line.
// Assumes the divider byte's top bit is the PWM enable and its low bits the ratio code.
module bl_pwm_top
    import bl_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out,
    output logic              bl_en
);
    localparam int CODE_W = DATA_W - 1;

    logic [DATA_W-1:0] div_q, duty_q, blen_q;
    logic              run_en;
    logic              tick;
    logic [DATA_W-1:0] pcnt, shadow;

    bl_pwm_regs #(.AW(ADDR_W), .DW(DATA_W), .NR(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .div_q(div_q), .duty_q(duty_q), .blen_q(blen_q)
    );

    assign run_en = div_q[DATA_W-1];

    bl_pwm_prescale #(.CODE_W(CODE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(run_en),
        .code(div_q[CODE_W-1:0]), .tick(tick)
    );

    bl_pwm_core #(.CNT_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick),
        .duty(duty_q), .pwm(pwm_out), .pcnt(pcnt), .shadow(shadow)
    );

    assign bl_en = blen_q[0];

    // Only bit 0 of the backlight byte drives a line.
    logic unused_blen;
    assign unused_blen = ^blen_q[DATA_W-1:1];
endmodule

// File: rtl/bl_pwm_chk.sv
// Module: bl_pwm_chk
// Checker for bl_pwm_top, bound to every instance of the top module.
// Assumes the internal names run_en, tick, pcnt and shadow of the top.
module bl_pwm_chk
    import bl_pwm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_data0,
    input logic              pwm_out,
    input logic              bl_en,
    input logic              run_en,
    input logic              tick,
    input logic [DATA_W-1:0] pcnt,
    input logic [DATA_W-1:0] shadow
);
    // R3: disabled output is low
    a_r3_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !pwm_out);

    // R3: counter held at zero while disabled
    a_r3_counter_held: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (pcnt == '0));

    // R4: counter steps by one on each tick
    a_r4_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick) |=> (pcnt == $past(pcnt) + 1'b1));

    // R5: last tick of a period is always low
    a_r5_last_tick_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pcnt == '1) |-> !pwm_out);

    // R6: shadow duty holds between wraps while running
    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !(tick && pcnt == '1)) |=> $stable(shadow));

    // R7: backlight line follows a write to its byte
    a_r7_blen_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_BLEN) |=> (bl_en == $past(wr_data0)));
endmodule

bind bl_pwm_top bl_pwm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data0(wr_data[0]), .pwm_out(pwm_out), .bl_en(bl_en),
    .run_en(run_en), .tick(tick), .pcnt(pcnt), .shadow(shadow)
);

// File: tb/bl_pwm_top_tb.sv
module bl_pwm_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 180000;
    localparam logic [7:0] A_DIV  = 8'h4B;
    localparam logic [7:0] A_DUTY = 8'h4E;
    localparam logic [7:0] A_BLEN = 8'h51;
    localparam int NV = 7;
    // {ratio code, duty}
    localparam logic [15:0] VEC [NV] = '{
        16'h00_00, 16'h00_FF, 16'h00_80, 16'h01_01,
        16'h03_40, 16'h02_C8, 16'h7F_0A
    };

    logic clk = 0, rst_n = 0, wr_en = 0;
    logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
    logic [7:0] rd_data;
    logic pwm_out, bl_en;
    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bl_pwm_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .bl_en(bl_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge; returns at the falling edge after the capture edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    // Count high samples over n falling edges starting at the current one.
    task automatic measure(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            hi += int'(pwm_out);
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int hi, per;
        logic first;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(A_DIV, v);  chk("R1 div", v, 0);
        rd(A_DUTY, v); chk("R1 duty", v, 0);
        rd(A_BLEN, v); chk("R1 blen", v, 0);
        chk("R1 pwm", pwm_out, 0);
        chk("R1 bl_en", bl_en, 0);
        rst_n = 1;

        // R4 R5 R8: table walk, each entry disables, loads, re-enables
        for (int k = 0; k < NV; k++) begin
            logic [7:0] code, duty;
            code = VEC[k][15:8]; duty = VEC[k][7:0];
            wr(A_DIV, code);
            wr(A_DUTY, duty);
            wr(A_DIV, 8'h80 | code);
            per = 256 * (int'(code) + 1);
            first = pwm_out;
            chk("R8 first sample after enable", first, duty != 0);
            measure(per, hi);
            chk("R5 high time per period", hi, int'(duty) * (int'(code) + 1));
            chk("R4 period restarts", pwm_out, first);
        end

        // R3: disabling holds the line low
        wr(A_DIV, 8'h00); wr(A_DUTY, 8'hFF); wr(A_DIV, 8'h80);
        chk("R3 running high", pwm_out, 1);
        wr(A_DIV, 8'h00);
        measure(300, hi);
        chk("R3 disabled low", hi, 0);
        rd(A_DIV, v); chk("R2 div readback", v, 8'h00);

        // R6: mid-period duty write applies at the wrap
        wr(A_DUTY, 8'd100); wr(A_DIV, 8'h80);
        hi = 0;
        for (int i = 0; i < 256; i++) begin
            if (i == 50) begin wr_en = 1; wr_addr = A_DUTY; wr_data = 8'd20; end
            if (i == 51) wr_en = 0;
            hi += int'(pwm_out);
            @(negedge clk);
        end
        chk("R6 current period keeps old duty", hi, 100);
        measure(256, hi);
        chk("R6 next period uses new duty", hi, 20);

        // R7: backlight line independent of PWM enable
        wr(A_BLEN, 8'h01);
        chk("R7 bl_en set while running", bl_en, 1);
        wr(A_DIV, 8'h00);
        chk("R7 bl_en kept after PWM off", bl_en, 1);
        chk("R7 pwm off", pwm_out, 0);
        wr(A_BLEN, 8'h00);
        chk("R7 bl_en cleared", bl_en, 0);

        // R2: readback of stored bytes and unused addresses
        wr(A_DIV, 8'h63); wr(A_BLEN, 8'hA5);
        rd(A_DIV, v);  chk("R2 div 0x63", v, 8'h63);
        rd(A_DUTY, v); chk("R2 duty", v, 20);
        rd(A_BLEN, v); chk("R2 blen", v, 8'hA5);
        chk("R7 bl_en from bit0", bl_en, 1);
        wr(8'h50, 8'hFF); wr(8'h4C, 8'h77);
        rd(8'h50, v);  chk("R2 unused reads 0", v, 0);
        rd(8'h4C, v);  chk("R2 unused reads 0 after write", v, 0);
        rd(A_DIV, v);  chk("R2 div untouched", v, 8'h63);
        rd(A_DUTY, v); chk("R2 duty untouched", v, 20);
        rd(A_BLEN, v); chk("R2 blen untouched", v, 8'hA5);

        // R1: reset mid-operation
        wr(A_DIV, 8'h80);
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        rd(A_DIV, v);  chk("R1 div after reset", v, 0);
        rd(A_BLEN, v); chk("R1 blen after reset", v, 0);
        chk("R1 pwm after reset", pwm_out, 0);
        chk("R1 bl_en after reset", bl_en, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule